// File: doc/BRIEF.md
# Binarized 3x3 Convolution Mismatch Engine

This block produces one output point of a binarized 3x3 convolution per accepted window. A window carries nine tap pairs. Each pair is a 6-bit activation word and a 6-bit weight word, and every bit is a sign bit (0 stands for +1, 1 stands for -1). For each tap the engine XORs the two words, which marks every bit position where the signs disagree. It counts those marked bits with a balanced adder tree. It then adds the nine per-tap counts with a second adder tree. The disagreement total is turned into the ±1 dot product, which is the number of agreeing bits minus the number of disagreeing bits.

The whole window arrives in one valid/ready beat, so a new output can start on every cycle. There is no loop-carried accumulator anywhere in the datapath. The pipeline has three register stages:
- XOR
- per-tap count
- window sum and signed mapping

When the consumer withholds ready, all three stages stall together. Feature-map addressing, line buffering and weight storage sit outside the block.

Top module: `bcx_engine`

## Requirements
- R1: For tap k, the activation word is `act_win[6k+5:6k]` and the weight word is `wgt_win[6k+5:6k]`, for k = 0..8. Tap k's bits are combined bitwise with XOR.
- R2: The mismatch count of a tap is the number of set bits among its 6 XOR bits, a value from 0 to 6.
- R3: `res_data` equals 54 minus twice the sum of the nine mismatch counts, as a signed 32-bit two's-complement value.
- R4: When `win_valid` and `win_ready` are both high at a rising edge, the full nine-tap window is accepted in that single beat.
- R5: If the output is never stalled, a window accepted at rising edge n is presented with `res_valid` high after rising edge n+2.
- R6: While `res_valid` is high and `res_ready` is low, `res_data` and `res_valid` hold their values at the next edge.
- R7: `win_ready` is high exactly when `res_valid` is low or `res_ready` is high.
- R8: While `rst_n` is low at a rising edge, every stage is emptied, so `res_valid` is low after that edge.
- R9: Identical activation and weight words on all taps give +54. Bitwise complementary words on all taps give -54.
- R10: An edge where `win_valid` is low, or where `win_ready` is low, produces no result. The data present on the inputs at such an edge never appears at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| win_valid | input | 1 | Window beat is valid |
| win_ready | output | 1 | Engine can take a window this cycle |
| act_win | input | 54 | Nine packed 6-bit activation words, tap 0 in the low bits |
| wgt_win | input | 54 | Nine packed 6-bit weight words, tap 0 in the low bits |
| res_valid | output | 1 | Result is valid |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 32 | Signed ±1 dot product of the window |

## Verification
The assertions assume three things about the environment. `rst_n` is driven low for at least one edge before traffic starts. `res_ready` is a clean level that is never X once reset is released. Input data is a defined value whenever `win_valid` is high.

The stimulus meets these assumptions by construction. It holds reset for several edges, drives every input only on the falling clock edge, and keeps the data buses at known values even during bubbles, so the range and parity checks on `res_data` never see undefined operands.

The stimulus covers the full 4-batch, 8x8-map, 16-filter, 6x6-output sweep, plus the two saturating corner windows. It mixes idle gaps on `win_valid` with periodic stalls on `res_ready`. It finishes with a reset applied while the pipeline is full.

// File: rtl/bcx_pkg.sv
package bcx_pkg;
    localparam int BCX_WORD_W = 6;
    localparam int BCX_TAPS   = 9;
    localparam int BCX_RES_W  = 32;
endpackage

// File: rtl/bcx_xor_stage.sv
module bcx_xor_stage #(
    parameter int WORD_W = 6,
    parameter int TAPS   = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     in_v,
    input  logic [TAPS*WORD_W-1:0]   act,
    input  logic [TAPS*WORD_W-1:0]   wgt,
    output logic                     out_v,
    output logic [TAPS*WORD_W-1:0]   diff
);
    localparam int BUS_W = TAPS * WORD_W;

    typedef struct packed {
        logic             v;
        logic [BUS_W-1:0] x;
    } xs_t;

    xs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.v = in_v;
            st_d.x = act ^ wgt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (!rst_n) st_q.v <= 1'b0;
    end

    assign out_v = st_q.v;
    assign diff  = st_q.x;

    p_clear_r8: assert property (@(posedge clk) !rst_n |=> !out_v);
endmodule

// File: rtl/bcx_tree_add.sv
module bcx_tree_add #(
    parameter int LEAVES = 6,
    parameter int IN_W   = 1,
    parameter int OUT_W  = 3
) (
    input  logic [LEAVES*IN_W-1:0] leaves,
    output logic [OUT_W-1:0]       total
);
    localparam int LVL = (LEAVES > 1) ? $clog2(LEAVES) : 1;
    localparam int PAD = 1 << LVL;

    for (genvar l = 0; l <= LVL; l++) begin : g_lvl
        logic [OUT_W-1:0] node [PAD >> l];
        for (genvar i = 0; i < (PAD >> l); i++) begin : g_node
            if (l == 0) begin : g_leaf
                if (i < LEAVES) begin : g_real
                    assign node[i] = OUT_W'(leaves[i*IN_W +: IN_W]);
                end else begin : g_pad
                    assign node[i] = '0;
                end
            end else begin : g_add
                assign node[i] = g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
            end
        end
    end

    assign total = g_lvl[LVL].node[0];
endmodule

// File: rtl/bcx_count_stage.sv
module bcx_count_stage #(
    parameter int WORD_W = 6,
    parameter int TAPS   = 9,
    parameter int CNT_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    in_v,
    input  logic [TAPS*WORD_W-1:0]  diff,
    output logic                    out_v,
    output logic [TAPS*CNT_W-1:0]   counts
);
    typedef struct packed {
        logic                  v;
        logic [TAPS*CNT_W-1:0] c;
    } cs_t;

    cs_t st_d, st_q;
    logic [TAPS*CNT_W-1:0] cnt_w;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        bcx_tree_add #(
            .LEAVES(WORD_W),
            .IN_W  (1),
            .OUT_W (CNT_W)
        ) i_pop (
            .leaves(diff[k*WORD_W +: WORD_W]),
            .total (cnt_w[k*CNT_W +: CNT_W])
        );
    end

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.v = in_v;
            st_d.c = cnt_w;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (!rst_n) st_q.v <= 1'b0;
    end

    assign out_v  = st_q.v;
    assign counts = st_q.c;

    for (genvar k = 0; k < TAPS; k++) begin : g_chk
        p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_v |-> (counts[k*CNT_W +: CNT_W] <= CNT_W'(WORD_W)));
    end
endmodule

// File: rtl/bcx_sum_stage.sv
module bcx_sum_stage #(
    parameter int WORD_W = 6,
    parameter int TAPS   = 9,
    parameter int CNT_W  = 3,
    parameter int RES_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    in_v,
    input  logic [TAPS*CNT_W-1:0]   counts,
    output logic                    out_v,
    output logic [RES_W-1:0]        result
);
    localparam int TOTAL = TAPS * WORD_W;
    localparam int SUM_W = $clog2(TOTAL + 1);

    typedef struct packed {
        logic             v;
        logic [RES_W-1:0] r;
    } ss_t;

    ss_t st_d, st_q;
    logic [SUM_W-1:0] mism;
    logic [RES_W-1:0] tot_u, dbl_u;

    bcx_tree_add #(
        .LEAVES(TAPS),
        .IN_W  (CNT_W),
        .OUT_W (SUM_W)
    ) i_sum (
        .leaves(counts),
        .total (mism)
    );

    always_comb begin
        tot_u = RES_W'(TOTAL);
        dbl_u = RES_W'(mism) << 1;
        st_d  = st_q;
        if (en) begin
            st_d.v = in_v;
            st_d.r = tot_u - dbl_u;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (!rst_n) st_q.v <= 1'b0;
    end

    assign out_v  = st_q.v;
    assign result = st_q.r;

    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_v |-> ($signed(result) <= TOTAL && $signed(result) >= -TOTAL && !result[0]));
    p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && in_v) |=> out_v);
endmodule

// File: rtl/bcx_engine.sv
module bcx_engine
    import bcx_pkg::*;
#(
    parameter int WORD_W = BCX_WORD_W,
    parameter int TAPS   = BCX_TAPS,
    parameter int RES_W  = BCX_RES_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    win_valid,
    output logic                    win_ready,
    input  logic [TAPS*WORD_W-1:0]  act_win,
    input  logic [TAPS*WORD_W-1:0]  wgt_win,
    output logic                    res_valid,
    input  logic                    res_ready,
    output logic [RES_W-1:0]        res_data
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic                   adv;
    logic                   x_v, c_v;
    logic [TAPS*WORD_W-1:0] x_bits;
    logic [TAPS*CNT_W-1:0]  c_bits;

    assign adv       = !res_valid || res_ready;
    assign win_ready = adv;

    bcx_xor_stage #(.WORD_W(WORD_W), .TAPS(TAPS)) i_xor (
        .clk(clk), .rst_n(rst_n), .en(adv), .in_v(win_valid),
        .act(act_win), .wgt(wgt_win), .out_v(x_v), .diff(x_bits)
    );

    bcx_count_stage #(.WORD_W(WORD_W), .TAPS(TAPS), .CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .en(adv), .in_v(x_v),
        .diff(x_bits), .out_v(c_v), .counts(c_bits)
    );

    bcx_sum_stage #(.WORD_W(WORD_W), .TAPS(TAPS), .CNT_W(CNT_W), .RES_W(RES_W)) i_sum (
        .clk(clk), .rst_n(rst_n), .en(adv), .in_v(c_v),
        .counts(c_bits), .out_v(res_valid), .result(res_data)
    );

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
    p_stall_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |-> !win_ready);
    p_reset_out_r8: assert property (@(posedge clk) !rst_n |=> !res_valid);
endmodule

// File: tb/test_bcx_engine.sv
module test_bcx_engine;
    localparam int W = 6;
    localparam int T = 9;
    localparam int NWIN = 4 * 6 * 6 * 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          win_valid = 1'b0;
    logic          win_ready;
    logic [T*W-1:0] act_win = '0;
    logic [T*W-1:0] wgt_win = '0;
    logic          res_valid;
    logic          res_ready = 1'b0;
    logic [31:0]   res_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    bit     mv [3];
    integer md [3];
    bit     acc_last;

    bcx_engine i_bcx_engine (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_ready(win_ready),
        .act_win(act_win), .wgt_win(wgt_win), .res_valid(res_valid),
        .res_ready(res_ready), .res_data(res_data)
    );

    always #2 clk = ~clk;

    function automatic integer ref_dot(input logic [T*W-1:0] a, input logic [T*W-1:0] b);
        integer m = 0;
        for (int k = 0; k < T; k++)
            for (int i = 0; i < W; i++)
                if (a[k*W+i] != b[k*W+i]) m++;
        return 54 - 2 * m;
    endfunction

    // behavioural reference: three slots, whole pipe moves when the output is free
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int s = 0; s < 3; s++) mv[s] = 1'b0;
            acc_last = 1'b0;
        end else begin
            bit go;
            go = !mv[2] || res_ready;
            acc_last = go && win_valid;
            if (go) begin
                mv[2] = mv[1]; md[2] = md[1];
                mv[1] = mv[0]; md[1] = md[0];
                mv[0] = win_valid; md[0] = ref_dot(act_win, wgt_win);
            end
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R7", "win_ready", longint'(win_ready), longint'(!mv[2] || res_ready));
        check("R5", "res_valid", longint'(res_valid), longint'(mv[2]));
        if (mv[2]) check("R3", "res_data", longint'($signed(res_data)), longint'(md[2]));
    endtask

    function automatic logic [W-1:0] amap(int n, int h, int w);
        return W'((n * 37 + h * 11 + w * 5 + h * w) % 64);
    endfunction

    function automatic logic [W-1:0] wmap(int c, int r, int s);
        return W'((c * 13 + r * 7 + s * 3 + c * r + 1) % 64);
    endfunction

    initial begin
        int idx;
        int corner_seen;
        for (int s = 0; s < 3; s++) begin mv[s] = 1'b0; md[s] = 0; end
        acc_last = 1'b0;
        repeat (4) @(negedge clk);
        check("R8", "res_valid in reset", longint'(res_valid), 0);
        rst_n = 1'b1;

        // R9 corners: identical words, then complementary words, no stall
        @(negedge clk);
        res_ready = 1'b1;
        win_valid = 1'b1;
        act_win = {9{6'b101101}};
        wgt_win = {9{6'b101101}};
        @(negedge clk);
        compare_all();
        wgt_win = ~act_win;
        @(negedge clk);
        compare_all();
        win_valid = 1'b0;
        act_win = '1;
        wgt_win = '0;
        corner_seen = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            compare_all();
            if (res_valid) begin
                check("R9", "corner value", longint'($signed(res_data)),
                      (corner_seen == 0) ? 54 : -54);
                corner_seen++;
            end
        end
        check("R10", "no output from idle junk", longint'(res_valid), 0);

        // R1 R4 R6: full sweep with gaps and stalls
        idx = 0;
        while (idx < NWIN || mv[0] || mv[1] || mv[2]) begin
            @(negedge clk);
            compare_all();
            if (win_valid && acc_last) idx++;
            res_ready = (cyc % 7) != 3 && (cyc % 11) != 5;
            if (!win_valid || acc_last) begin
                if (idx < NWIN && (cyc % 5) != 2) begin
                    int c, ow, oh, n, k;
                    c  = idx % 16;
                    ow = (idx / 16) % 6;
                    oh = (idx / 96) % 6;
                    n  = idx / 576;
                    k  = 0;
                    for (int r = 0; r < 3; r++)
                        for (int s = 0; s < 3; s++) begin
                            act_win[k*W +: W] = amap(n, oh + r, ow + s);
                            wgt_win[k*W +: W] = wmap(c, r, s);
                            k++;
                        end
                    win_valid = 1'b1;
                end else begin
                    win_valid = 1'b0;
                    act_win = ~act_win;
                end
            end
            if (cyc > 150000) break;
        end
        check("R1", "all windows delivered", longint'(idx), longint'(NWIN));

        // R8 reset with a full pipe
        res_ready = 1'b0;
        win_valid = 1'b1;
        repeat (4) @(negedge clk);
        check("R6", "stalled output valid", longint'(res_valid), 1);
        rst_n = 1'b0;
        win_valid = 1'b0;
        @(negedge clk);
        check("R8", "res_valid after reset", longint'(res_valid), 0);
        check("R8", "win_ready after reset", longint'(win_ready), 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule